// File: doc/BRIEF.md
# Interrupt enable register bank with set/clear addressing

This block holds the enable state of an interrupt controller in a set of memory-mapped registers. Two kinds of register exist. Enable-mask registers use one bit per interrupt source and are reached through two addresses. Writing the set address turns bits on, and writing the clear address turns bits off. Priority registers are split into multi-bit fields. They have one address, and a write there replaces the whole value. A priority field that holds any nonzero value counts as an enable for its source.

Every write is compared with the value it replaces. Each field whose value changed becomes an enable event. The event is a grant if the field is now nonzero and a revoke if it is now zero. The event goes out as a single-cycle pulse carrying a source identifier. A field can map to a group identifier instead of a real source. A group emits nothing itself. It passes the event along a chain of member sources, one member per clock, and each member emits its own pulse.

While events are still draining, `busy` is high and writes are refused. Reads are accepted at any time. Both the mapping from fields to identifiers and the chain links are parameters, so an integration supplies its own interrupt layout.

Top module: `irq_enable_bank`

## Requirements
- R1: After reset every register reads zero, `busy` is low and `enValid` is low.
- R2: Enable-mask register i has its set address at MASK_BASE+8*i. An accepted write there stores the old value ORed with `wrData`.
- R3: The clear address of enable-mask register i is MASK_BASE+8*i+4. An accepted write there stores the old value ANDed with the inverse of `wrData`.
- R4: Priority register j sits at PRIO_BASE+4*j. An accepted write there stores `wrData` unchanged.
- R5: A read (`rdEn`) updates `rdData` on the next clock edge. At a register's set or clear address it returns that register's stored value. At any other address it returns zero.
- R6: Address bits above bit 28 are ignored for both reads and writes.
- R7: Mask registers have one-bit fields. Priority registers have PFW-bit fields, where field 0 is the most significant. Each field of a written register that changed produces exactly one event, and unchanged fields produce none. Events leave in order from the most significant field down. `enGrant` is 1 when the new field value is nonzero and 0 when it is zero.
- R8: A field mapped to identifier 0 produces no pulse. So does a field mapped to a reserved identifier, meaning one with no vector and no chain link.
- R9: A field mapped to an identifier without a vector forwards its event along NEXT_MAP. Each member that has a vector pulses, and each member forwards to its own link until a link of 0. An identifier that has a vector and is reached straight from a field pulses once and does not forward.
- R10: `busy` rises on the cycle after an accepted write that changed any field. It stays high until the last pulse of that write. A write presented while `busy` is high is discarded.
- R11: `enValid` is asserted only while `busy` is high, and never carries identifier 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, taken only when `busy` is low |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; only bits 28:0 are decoded |
| wrData | input | REG_W | Write data |
| rdData | output | REG_W | Read data, registered |
| busy | output | 1 | Enable events still draining; writes refused |
| enValid | output | 1 | Enable event pulse |
| enSrc | output | ID_W | Source identifier of the event |
| enGrant | output | 1 | 1 grants, 0 revokes the enable |

## Verification
The embedded properties assume that a write is held for a single cycle and never arrives while `busy` is high unless the test wants it dropped. The bench satisfies this by waiting for `busy` to fall after every write. The one exception is a deliberate back-to-back pair that exercises the drop. The properties also assume that each address selects at most one register. The bench's bases are spaced so that the mask, clear and priority addresses never overlap.

The stimulus sweeps every value of one priority register and runs long set/clear sequences on both mask registers. The bench's field map deliberately includes an identifier-0 field, a reserved identifier, two group chains and a directly mapped chain member.

// File: rtl/enbank_pkg.sv
package enbank_pkg;

  // Default configuration used when the top is elaborated without overrides
  localparam int DEF_NMASK = 2;
  localparam int DEF_NPRIO = 2;
  localparam int DEF_REG_W = 8;
  localparam int DEF_PFW   = 4;
  localparam int DEF_ID_W  = 5;
  localparam int DEF_NF    = DEF_NMASK * DEF_REG_W + DEF_NPRIO * (DEF_REG_W / DEF_PFW);
  localparam int DEF_NSRC  = 1 << DEF_ID_W;

  // Strobes from the walker to the datapath
  typedef struct packed {
    logic pick;    // take the next pending field, load its identifier
    logic follow;  // step to the chain link of the current identifier
  } walkCtl_t;

  // State reported by the datapath to the walker
  typedef struct packed {
    logic anyPend;
    logic curZero;
    logic curVec;
    logic curHasNext;
    logic curChain;
  } walkSts_t;

  // Default map: field f drives identifier f+1
  function automatic logic [DEF_NF*DEF_ID_W-1:0] defFieldMap();
    logic [DEF_NF*DEF_ID_W-1:0] m;
    m = '0;
    for (int f = 0; f < DEF_NF; f++) m[f*DEF_ID_W +: DEF_ID_W] = DEF_ID_W'(f + 1);
    return m;
  endfunction

endpackage

// File: rtl/enbank_datapath.sv
module enbank_datapath
  import enbank_pkg::*;
#(
  parameter int          NMASK     = 2,
  parameter int          NPRIO     = 2,
  parameter int          REG_W     = 8,
  parameter int          PFW       = 4,
  parameter int          ID_W      = 5,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] MASK_BASE = 32'h0000_4000,
  parameter logic [31:0] PRIO_BASE = 32'h0000_4100,
  parameter int          NF        = NMASK * REG_W + NPRIO * (REG_W / PFW),
  parameter logic [NF*ID_W-1:0]          FIELD_MAP = '0,
  parameter logic [(1<<ID_W)*ID_W-1:0]   NEXT_MAP  = '0,
  parameter logic [(1<<ID_W)-1:0]        VEC_MAP   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              busy,
  input  walkCtl_t          ctl,
  output walkSts_t          sts,
  output logic [REG_W-1:0]  rdData,
  output logic [ID_W-1:0]   curId,
  output logic              curGrant
);

  localparam int NREG = NMASK + NPRIO;
  localparam int PF   = REG_W / PFW;
  localparam int FW   = (NF > 1) ? $clog2(NF) : 1;

  logic [NREG-1:0][REG_W-1:0] regQ;
  logic [REG_W-1:0]           regD [NREG];
  logic                       setHit [NREG];
  logic                       clrHit [NREG];
  logic [28:0]                addrLo;
  logic [ADDR_W-30:0]         unusedAddrHi;
  logic                       wrAcc;
  logic [NF-1:0]              chgVec, grantVec, pendChg, pendGrant;
  logic [FW-1:0]              firstIdx;
  logic                       curChain;

  assign addrLo       = addr[28:0];
  assign unusedAddrHi = addr[ADDR_W-1:29];
  assign wrAcc        = wrEn & ~busy;

  // Mask registers: dual set/clear addressing
  for (genvar i = 0; i < NMASK; i++) begin : g_mask
    localparam logic [28:0] SETA = MASK_BASE[28:0] + 29'(8 * i);
    assign setHit[i] = (addrLo == SETA);
    assign clrHit[i] = (addrLo == SETA + 29'd4);
    assign regD[i]   = (wrAcc && setHit[i]) ? (regQ[i] | wrData) :
                       (wrAcc && clrHit[i]) ? (regQ[i] & ~wrData) : regQ[i];

    // R2
    set_or_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !busy && setHit[i]) |=> ((regQ[i] & $past(wrData)) == $past(wrData)) &&
                                       ((regQ[i] & ~$past(wrData)) == ($past(regQ[i]) & ~$past(wrData))));
    // R3
    clr_and_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !busy && clrHit[i]) |=> ((regQ[i] & $past(wrData)) == '0) &&
                                       ((regQ[i] | $past(wrData)) == ($past(regQ[i]) | $past(wrData))));
  end

  // Priority registers: single address, direct load
  for (genvar j = 0; j < NPRIO; j++) begin : g_prio
    localparam int R = NMASK + j;
    localparam logic [28:0] SETA = PRIO_BASE[28:0] + 29'(4 * j);
    assign setHit[R] = (addrLo == SETA);
    assign clrHit[R] = 1'b0;
    assign regD[R]   = (wrAcc && setHit[R]) ? wrData : regQ[R];

    // R4
    prio_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !busy && setHit[R]) |=> (regQ[R] == $past(wrData)));
  end

  // Change detection in global field order (most significant field first)
  always_comb begin
    chgVec   = '0;
    grantVec = '0;
    for (int i = 0; i < NMASK; i++) begin
      for (int b = 0; b < REG_W; b++) begin
        chgVec[i*REG_W + (REG_W-1-b)]   = regD[i][b] ^ regQ[i][b];
        grantVec[i*REG_W + (REG_W-1-b)] = regD[i][b];
      end
    end
    for (int j = 0; j < NPRIO; j++) begin
      for (int q = 0; q < PF; q++) begin
        chgVec[NMASK*REG_W + j*PF + q]   =
          (regD[NMASK+j][(PF-1-q)*PFW +: PFW] != regQ[NMASK+j][(PF-1-q)*PFW +: PFW]);
        grantVec[NMASK*REG_W + j*PF + q] = |regD[NMASK+j][(PF-1-q)*PFW +: PFW];
      end
    end
  end

  // Lowest pending index is the next field to serve
  always_comb begin
    firstIdx = '0;
    for (int f = NF - 1; f >= 0; f--) begin
      if (pendChg[f]) firstIdx = FW'(f);
    end
  end

  logic [REG_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    for (int r = 0; r < NREG; r++) begin
      if (setHit[r] || clrHit[r]) rdMux = regQ[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ      <= '0;
      pendChg   <= '0;
      pendGrant <= '0;
      curId     <= '0;
      curGrant  <= 1'b0;
      curChain  <= 1'b0;
      rdData    <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) regQ[r] <= regD[r];
      if (wrAcc) begin
        pendChg   <= chgVec;
        pendGrant <= grantVec;
      end else if (ctl.pick) begin
        pendChg   <= pendChg & ~(NF'(1) << firstIdx);
      end
      if (ctl.pick) begin
        curId    <= FIELD_MAP[firstIdx*ID_W +: ID_W];
        curGrant <= pendGrant[firstIdx];
        curChain <= 1'b0;
      end else if (ctl.follow) begin
        curId    <= NEXT_MAP[curId*ID_W +: ID_W];
        curChain <= 1'b1;
      end
      if (rdEn) rdData <= rdMux;
    end
  end

  assign sts.anyPend    = |pendChg;
  assign sts.curZero    = (curId == '0);
  assign sts.curVec     = VEC_MAP[curId];
  assign sts.curHasNext = (NEXT_MAP[curId*ID_W +: ID_W] != '0);
  assign sts.curChain   = curChain;

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> $stable(regQ));

endmodule

// File: rtl/enbank_walker.sv
module enbank_walker
  import enbank_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     inWalk
);

  typedef enum logic { W_IDLE, W_STEP } wState_t;

  wState_t stQ, stD;
  logic    canFollow;

  assign inWalk = (stQ == W_STEP);

  always_comb begin
    canFollow  = inWalk & ~sts.curZero & (sts.curChain | ~sts.curVec) & sts.curHasNext;
    ctl.follow = canFollow;
    ctl.pick   = ~canFollow & sts.anyPend;
    stD        = (ctl.pick | ctl.follow) ? W_STEP : W_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= W_IDLE;
    else       stQ <= stD;
  end

  // R9
  chain_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.follow |=> (inWalk && sts.curChain));

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import enbank_pkg::*;
#(
  parameter int          NMASK     = DEF_NMASK,
  parameter int          NPRIO     = DEF_NPRIO,
  parameter int          REG_W     = DEF_REG_W,
  parameter int          PFW       = DEF_PFW,
  parameter int          ID_W      = DEF_ID_W,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] MASK_BASE = 32'h0000_4000,
  parameter logic [31:0] PRIO_BASE = 32'h0000_4100,
  parameter logic [(NMASK*REG_W+NPRIO*(REG_W/PFW))*ID_W-1:0] FIELD_MAP = defFieldMap(),
  parameter logic [(1<<ID_W)*ID_W-1:0] NEXT_MAP = '0,
  parameter logic [(1<<ID_W)-1:0]      VEC_MAP  = {{((1<<ID_W)-1){1'b1}}, 1'b0}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              busy,
  output logic              enValid,
  output logic [ID_W-1:0]   enSrc,
  output logic              enGrant
);

  localparam int NF = NMASK * REG_W + NPRIO * (REG_W / PFW);

  walkCtl_t ctl;
  walkSts_t sts;
  logic     inWalk;

  enbank_datapath #(
    .NMASK(NMASK), .NPRIO(NPRIO), .REG_W(REG_W), .PFW(PFW), .ID_W(ID_W),
    .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE), .PRIO_BASE(PRIO_BASE), .NF(NF),
    .FIELD_MAP(FIELD_MAP), .NEXT_MAP(NEXT_MAP), .VEC_MAP(VEC_MAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .busy(busy), .ctl(ctl), .sts(sts), .rdData(rdData), .curId(enSrc), .curGrant(enGrant)
  );

  enbank_walker u_walk (
    .clk(clk), .rstN(rstN), .sts(sts), .ctl(ctl), .inWalk(inWalk)
  );

  assign busy    = sts.anyPend | inWalk;
  assign enValid = inWalk & ~sts.curZero & sts.curVec;

  // R11
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    enValid |-> (enSrc != '0));
  // R11
  pulse_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    enValid |-> busy);

endmodule

// File: tb/sim_irq_enable_bank.sv
module sim_irq_enable_bank;

  localparam int NM = 2, NP = 2, RW = 8, FWID = 4, IW = 5, NFLD = 20, NS = 32;
  localparam logic [31:0] MB = 32'h0000_4000;
  localparam logic [31:0] PB = 32'h0000_4100;

  // Bench interrupt layout
  function automatic int fieldId(int f);
    case (f)
      3:  return 0;   // unused field
      5:  return 20;  // group A
      10: return 25;  // reserved
      12: return 22;  // chain member mapped directly
      17: return 21;  // group B
      default: return f + 1;
    endcase
  endfunction

  function automatic int nextOf(int id);
    case (id)
      20: return 22;
      22: return 23;
      21: return 24;
      24: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit isVec(int id);
    return (id >= 1 && id <= 19) || id == 22 || id == 23 || id == 24;
  endfunction

  function automatic logic [NFLD*IW-1:0] mkField();
    logic [NFLD*IW-1:0] m;
    for (int f = 0; f < NFLD; f++) m[f*IW +: IW] = IW'(fieldId(f));
    return m;
  endfunction

  function automatic logic [NS*IW-1:0] mkNext();
    logic [NS*IW-1:0] m;
    for (int s = 0; s < NS; s++) m[s*IW +: IW] = IW'(nextOf(s));
    return m;
  endfunction

  function automatic logic [NS-1:0] mkVec();
    logic [NS-1:0] m;
    for (int s = 0; s < NS; s++) m[s] = isVec(s);
    return m;
  endfunction

  localparam logic [NFLD*IW-1:0] FMAP = mkField();
  localparam logic [NS*IW-1:0]   NMAP = mkNext();
  localparam logic [NS-1:0]      VMAP = mkVec();

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0]   addr = '0;
  logic [RW-1:0] wrData = '0;
  logic [RW-1:0] rdData;
  logic          busy, enValid, enGrant;
  logic [IW-1:0] enSrc;

  always #5 clk = ~clk;

  irq_enable_bank #(
    .NMASK(NM), .NPRIO(NP), .REG_W(RW), .PFW(FWID), .ID_W(IW), .ADDR_W(32),
    .MASK_BASE(MB), .PRIO_BASE(PB), .FIELD_MAP(FMAP), .NEXT_MAP(NMAP), .VEC_MAP(VMAP)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .busy(busy), .enValid(enValid), .enSrc(enSrc), .enGrant(enGrant)
  );

  int nChk = 0, nFail = 0;
  int expId [64];
  bit expG  [64];
  int expN = 0;
  int obsId [64];
  bit obsG  [64];
  int obsN = 0;
  bit badPulse = 1'b0;
  logic [RW-1:0] sh [NM+NP];

  always @(negedge clk) begin
    if (rstN && enValid) begin
      if (obsN < 64) begin
        obsId[obsN] = int'(enSrc);
        obsG[obsN]  = enGrant;
      end
      obsN = obsN + 1;
      if (enSrc == '0 || !busy) badPulse = 1'b1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(int id, bit g);
    if (expN < 64) begin
      expId[expN] = id;
      expG[expN]  = g;
    end
    expN++;
  endtask

  task automatic walk(int id0, bit g);
    int id = id0;
    bit ch = 1'b0;
    while (id != 0) begin
      if (isVec(id)) pushExp(id, g);
      if ((ch || !isVec(id)) && nextOf(id) != 0) begin
        id = nextOf(id);
        ch = 1'b1;
      end else begin
        id = 0;
      end
    end
  endtask

  task automatic modelWrite(int r, bit isClr, logic [RW-1:0] d);
    logic [RW-1:0] o, n;
    o = sh[r];
    if (r < NM) begin
      n = isClr ? (o & ~d) : (o | d);
      for (int b = RW - 1; b >= 0; b--)
        if (o[b] != n[b]) walk(fieldId(r*RW + RW - 1 - b), n[b]);
    end else begin
      n = d;
      for (int q = 0; q < RW / FWID; q++)
        if (o[(1-q)*FWID +: FWID] != n[(1-q)*FWID +: FWID])
          walk(fieldId(NM*RW + (r-NM)*2 + q), n[(1-q)*FWID +: FWID] != 0);
    end
    sh[r] = n;
  endtask

  function automatic logic [31:0] regAddr(int r, bit isClr);
    if (r < NM) return MB + 32'(8*r) + (isClr ? 32'd4 : 32'd0);
    return PB + 32'(4*(r-NM));
  endfunction

  task automatic doWr(logic [31:0] a, logic [RW-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRd(logic [31:0] a, output logic [RW-1:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic chkSeq(string tag);
    bit ok = (obsN == expN);
    for (int k = 0; k < 64; k++)
      if (ok && k < expN && (obsId[k] != expId[k] || obsG[k] != expG[k])) ok = 1'b0;
    chk(ok, tag, obsN, expN);
  endtask

  // One accepted write: sequence check, then read-back at the register's addresses
  task automatic op(int r, bit isClr, logic [RW-1:0] d, logic [31:0] hi, string seqTag, string rdTag);
    logic [RW-1:0] v;
    obsN = 0; expN = 0;
    modelWrite(r, isClr, d);
    doWr(regAddr(r, isClr) | hi, d);
    waitIdle();
    chkSeq(seqTag);
    doRd(regAddr(r, 1'b0) | hi, v);
    chk(v == sh[r], rdTag, int'(v), int'(sh[r]));
    if (r < NM) begin
      doRd(regAddr(r, 1'b1), v);
      chk(v == sh[r], "R5 clear-address read", int'(v), int'(sh[r]));
    end
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] v;
    for (int r = 0; r < NM + NP; r++) sh[r] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(enValid == 1'b0, "R1 enValid", int'(enValid), 0);
    for (int r = 0; r < NM + NP; r++) begin
      doRd(regAddr(r, 1'b0), v);
      chk(v == '0, "R1 reset value", int'(v), 0);
    end

    // R5 unmatched address reads zero
    doRd(PB + 32'h40, v);
    chk(v == '0, "R5 unmatched read", int'(v), 0);

    // R8 identifier-0 field (mask0 bit4) and reserved identifier (mask1 bit5)
    op(0, 1'b0, 8'h10, 32'h0, "R8 id0 field", "R2 read");
    op(1, 1'b0, 8'h20, 32'h0, "R8 reserved id", "R2 read");
    // R9 directly mapped chain member (mask1 bit3 -> id 22) does not forward
    op(1, 1'b0, 8'h08, 32'h0, "R9 direct member", "R2 read");
    // R9 group A (mask0 bit2) -> 22, 23
    op(0, 1'b0, 8'h04, 32'h0, "R9 group A grant", "R2 read");
    op(0, 1'b1, 8'h04, 32'h0, "R9 group A revoke", "R3 read");
    // R9 group B (prio0 low field) -> 24, 1
    op(2, 1'b0, 8'h03, 32'h0, "R9 group B grant", "R4 read");

    // R6 upper address bits ignored
    op(1, 1'b0, 8'h81, 32'hA000_0000, "R6 alias write seq", "R6 alias read");
    doRd(regAddr(1, 1'b0) | 32'hE000_0000, v);
    chk(v == sh[1], "R6 alias read high", int'(v), int'(sh[1]));

    // R10 write with no field change keeps busy low and emits nothing
    obsN = 0; expN = 0;
    doWr(regAddr(1, 1'b0), 8'h81);
    chk(busy == 1'b0, "R10 no-change busy", int'(busy), 0);
    waitIdle();
    chkSeq("R10 no-change pulses");

    // R10 back-pressure: second write while busy is dropped
    obsN = 0; expN = 0;
    modelWrite(0, 1'b0, 8'hE3);
    wrEn = 1'b1; addr = regAddr(0, 1'b0); wrData = 8'hE3;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy after write", int'(busy), 1);
    addr = regAddr(0, 1'b1); wrData = 8'hFF;
    @(negedge clk);
    wrEn = 1'b0;
    waitIdle();
    chkSeq("R10 dropped write pulses");
    doRd(regAddr(0, 1'b0), v);
    chk(v == sh[0], "R10 dropped write value", int'(v), int'(sh[0]));

    // R2 R3 R7 mask sweeps
    for (int r = 0; r < NM; r++) begin
      for (int it = 0; it < 64; it++) begin
        logic [RW-1:0] d;
        bit c;
        d = RW'((it * 37 + r * 91 + 5) ^ (it >> 1));
        c = (it % 3 == 2);
        op(r, c, d, 32'h0, "R7 mask sequence", c ? "R3 clear value" : "R2 set value");
      end
    end

    // R4 R7 exhaustive priority sweep on register 0, patterns on register 1
    for (int val = 0; val < 256; val++)
      op(2, 1'b0, RW'(val ^ (val >> 3)), 32'h0, "R7 prio sequence", "R4 prio value");
    for (int it = 0; it < 32; it++)
      op(3, 1'b0, RW'(it * 53), 32'h0, "R7 prio1 sequence", "R4 prio1 value");

    // R11 pulse sanity over the whole run
    chk(badPulse == 1'b0, "R11 pulse id/busy", int'(badPulse), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule